// File: doc/BRIEF.md
# CPU Status Latch and Bus Control Decoder

This block connects an 8-bit microprocessor with a multiplexed data bus to the system memory and I/O buses. At the start of every machine cycle the processor places a status byte on its data bus and a status strobe pulses. The block captures that byte in an 8-bit register. It samples the byte on the processor side of the data bus, ahead of the bus buffer, so capture still works while the buffer is disabled for DMA.

The latched status is combined with the processor's live read-enable (`dbin`) and active-low write (`wrN`) lines. This produces five active-low strobes: memory read, memory write, I/O read, I/O write and interrupt acknowledge. The interrupt acknowledge strobe enables the port that supplies the restart instruction. The block also sets the direction of the bidirectional data buffer and raises the output enables of the data and address buffers. A bus-enable input takes all buffers and strobes off the bus so that another master can drive it. Four latched status bits go straight to diagnostic pins.

Top module: `cpuBusCtl`

## Requirements
- R1: While `rstN` is low the status register holds 8'h02. In that state no strobe is asserted for any `dbin`/`wrN` value, `diagWoN` is 1, and `diagStack`, `diagHltAck` and `diagM1` are 0. A status strobe during reset is ignored.
- R2: On a rising clock edge with `stsStrobe` high, the register loads `procData`. The outputs follow the old status up to that edge and the new status after it.
- R3: While `stsStrobe` is low the register keeps its value, whatever `procData` does.
- R4: `memRdN` is low exactly when `busEn`, `dbin` and status bit 7 (memory read) are all 1.
- R5: `ioRdN` is low exactly when `busEn`, `dbin` and status bit 6 (input) are all 1.
- R6: `memWrN` is low exactly when `busEn` is 1, `wrN` is 0, status bit 1 (write-output, active low) is 0 and status bit 4 (output) is 0.
- R7: `ioWrN` is low exactly when `busEn` is 1, `wrN` is 0, status bit 1 is 0 and status bit 4 is 1.
- R8: `intAckN` is low exactly when `busEn`, `dbin` and status bit 0 (interrupt acknowledge) are all 1.
- R9: `dataOeToCpu` equals `busEn & dbin` and `dataOeToSys` equals `busEn & ~dbin`. The two are never both high.
- R10: While `busEn` is 0, all five strobes are high and `dataOeToCpu`, `dataOeToSys` and `addrOe` are 0. `addrOe` equals `busEn`.
- R11: A status strobe given while `busEn` is 0 still loads the register.
- R12: `diagWoN`, `diagStack`, `diagHltAck` and `diagM1` show latched status bits 1, 2, 3 and 5, independent of `busEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stsStrobe | input | 1 | Status capture strobe, sampled on the rising edge |
| procData | input | 8 | Processor-side data bus carrying status |
| dbin | input | 1 | Processor read enable, high = data toward processor |
| wrN | input | 1 | Processor write, active low |
| busEn | input | 1 | Bus enable, low releases buses for DMA |
| memRdN | output | 1 | Memory read strobe, active low |
| memWrN | output | 1 | Memory write strobe, active low |
| ioRdN | output | 1 | I/O read strobe, active low |
| ioWrN | output | 1 | I/O write strobe, active low |
| intAckN | output | 1 | Interrupt acknowledge strobe, active low |
| dataOeToCpu | output | 1 | Data buffer drives toward processor |
| dataOeToSys | output | 1 | Data buffer drives toward system bus |
| addrOe | output | 1 | Address buffer output enable (all 16 lines) |
| diagWoN | output | 1 | Latched write-output status bit |
| diagStack | output | 1 | Latched stack status bit |
| diagHltAck | output | 1 | Latched halt-acknowledge status bit |
| diagM1 | output | 1 | Latched M1 status bit |

## Verification
Status capture and strobe decoding can fall in the same cycle. A new status byte can be strobed while `dbin` or `wrN` is still active and a strobe is decoding from the previous byte. The bench provokes this on every load: it keeps the read/write lines active from the previous combination and presents a different byte together with the strobe. Before the capturing edge it requires outputs decoded from the old byte, and after the edge outputs decoded from the new one. The same overlap is driven with `busEn` low, to show that capture is independent of the buffer state.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;
  localparam int STS_W  = 8;
  localparam int B_INTA = 0;
  localparam int B_WO   = 1;
  localparam int B_STK  = 2;
  localparam int B_HLTA = 3;
  localparam int B_OUT  = 4;
  localparam int B_M1   = 5;
  localparam int B_INP  = 6;
  localparam int B_MEMR = 7;
  // idle value: write-output inactive (high), everything else clear
  localparam logic [STS_W-1:0] STS_RESET = STS_W'(1) << B_WO;

  typedef struct packed {
    logic memRd;
    logic ioRd;
    logic intAck;
    logic memWr;
    logic ioWr;
    logic toCpu;
    logic toSys;
    logic addrEn;
  } busCmd_t;

  typedef struct packed {
    logic memRd;
    logic inp;
    logic out;
    logic woN;
    logic intAck;
  } decFields_t;
endpackage

// File: rtl/cpuStsPath.sv
module cpuStsPath
  import cpu_bus_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             stsStrobe,
  input  logic [STS_W-1:0] procData,
  input  busCmd_t          cmd,
  output decFields_t       fields,
  output logic             memRdN,
  output logic             memWrN,
  output logic             ioRdN,
  output logic             ioWrN,
  output logic             intAckN,
  output logic             dataOeToCpu,
  output logic             dataOeToSys,
  output logic             addrOe,
  output logic             diagWoN,
  output logic             diagStack,
  output logic             diagHltAck,
  output logic             diagM1
);
  logic [STS_W-1:0] stsReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          stsReg <= STS_RESET;
    else if (stsStrobe) stsReg <= procData;
  end

  always_comb begin
    fields.memRd  = stsReg[B_MEMR];
    fields.inp    = stsReg[B_INP];
    fields.out    = stsReg[B_OUT];
    fields.woN    = stsReg[B_WO];
    fields.intAck = stsReg[B_INTA];
  end

  assign memRdN      = ~cmd.memRd;
  assign memWrN      = ~cmd.memWr;
  assign ioRdN       = ~cmd.ioRd;
  assign ioWrN       = ~cmd.ioWr;
  assign intAckN     = ~cmd.intAck;
  assign dataOeToCpu = cmd.toCpu;
  assign dataOeToSys = cmd.toSys;
  assign addrOe      = cmd.addrEn;

  assign diagWoN    = stsReg[B_WO];
  assign diagStack  = stsReg[B_STK];
  assign diagHltAck = stsReg[B_HLTA];
  assign diagM1     = stsReg[B_M1];

  // R3
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stsStrobe |=> $stable(stsReg));

  // R2
  sts_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stsStrobe |=> (stsReg == $past(procData)));

  // R9
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dataOeToCpu && dataOeToSys));

  // R10
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrOe |-> (memRdN && memWrN && ioRdN && ioWrN && intAckN));
endmodule

// File: rtl/cpuCtlDecode.sv
module cpuCtlDecode
  import cpu_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  decFields_t fields,
  input  logic       dbin,
  input  logic       wrN,
  input  logic       busEn,
  output busCmd_t    cmd
);
  logic rdQual;
  logic wrQual;

  always_comb begin
    rdQual     = busEn & dbin;
    wrQual     = busEn & ~wrN & ~fields.woN;
    cmd.memRd  = rdQual & fields.memRd;
    cmd.ioRd   = rdQual & fields.inp;
    cmd.intAck = rdQual & fields.intAck;
    cmd.memWr  = wrQual & ~fields.out;
    cmd.ioWr   = wrQual & fields.out;
    cmd.toCpu  = busEn & dbin;
    cmd.toSys  = busEn & ~dbin;
    cmd.addrEn = busEn;
  end

  // R10
  bus_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |-> (cmd == '0));

  // R6 R7
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.memWr || cmd.ioWr) |-> (!wrN && !fields.woN));

  // R4 R5 R8
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.memRd || cmd.ioRd || cmd.intAck) |-> dbin);
endmodule

// File: rtl/cpuBusCtl.sv
module cpuBusCtl
  import cpu_bus_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             stsStrobe,
  input  logic [STS_W-1:0] procData,
  input  logic             dbin,
  input  logic             wrN,
  input  logic             busEn,
  output logic             memRdN,
  output logic             memWrN,
  output logic             ioRdN,
  output logic             ioWrN,
  output logic             intAckN,
  output logic             dataOeToCpu,
  output logic             dataOeToSys,
  output logic             addrOe,
  output logic             diagWoN,
  output logic             diagStack,
  output logic             diagHltAck,
  output logic             diagM1
);
  decFields_t fields;
  busCmd_t    cmd;

  cpuStsPath u_path (
    .clk(clk), .rstN(rstN), .stsStrobe(stsStrobe), .procData(procData),
    .cmd(cmd), .fields(fields),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .intAckN(intAckN), .dataOeToCpu(dataOeToCpu), .dataOeToSys(dataOeToSys),
    .addrOe(addrOe), .diagWoN(diagWoN), .diagStack(diagStack),
    .diagHltAck(diagHltAck), .diagM1(diagM1)
  );

  cpuCtlDecode u_ctl (
    .clk(clk), .rstN(rstN), .fields(fields), .dbin(dbin), .wrN(wrN),
    .busEn(busEn), .cmd(cmd)
  );
endmodule

// File: tb/cpuBusCtl_bench.sv
module cpuBusCtl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stsStrobe = 1'b0;
  logic [7:0] procData = 8'h00;
  logic dbin = 1'b0;
  logic wrN = 1'b1;
  logic busEn = 1'b1;
  logic memRdN, memWrN, ioRdN, ioWrN, intAckN;
  logic dataOeToCpu, dataOeToSys, addrOe;
  logic diagWoN, diagStack, diagHltAck, diagM1;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] modelSts = 8'h02;

  typedef struct {
    logic [11:0] e;
    string       tag;
    logic        be;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  cpuBusCtl u_cpuBusCtl (
    .clk(clk), .rstN(rstN), .stsStrobe(stsStrobe), .procData(procData),
    .dbin(dbin), .wrN(wrN), .busEn(busEn),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .intAckN(intAckN), .dataOeToCpu(dataOeToCpu), .dataOeToSys(dataOeToSys),
    .addrOe(addrOe), .diagWoN(diagWoN), .diagStack(diagStack),
    .diagHltAck(diagHltAck), .diagM1(diagM1)
  );

  // reference model written from R4..R12
  function automatic logic [11:0] model(logic [7:0] s, logic d, logic w, logic be);
    logic rq, wq;
    rq = be & d;
    wq = be & ~w & ~s[1];
    return {~(rq & s[7]), ~(wq & ~s[4]), ~(rq & s[6]), ~(wq & s[4]),
            ~(rq & s[0]), be & d, be & ~d, be, s[1], s[2], s[3], s[5]};
  endfunction

  function automatic string reqOf(int idx, string tag, logic be);
    if (tag != "") return tag;
    if (!be && idx >= 4) return "R10";
    case (idx)
      11: return "R4";
      10: return "R6";
      9:  return "R5";
      8:  return "R7";
      7:  return "R8";
      6, 5: return "R9";
      4:  return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic push(string tag);
    item_t it;
    it.e = model(modelSts, dbin, wrN, busEn);
    it.tag = tag;
    it.be = busEn;
    sbq.push_back(it);
  endtask

  // R2 R11: load a byte while read/write lines stay as they are
  task automatic loadSts(logic [7:0] v, logic be);
    @(negedge clk);
    procData = v;
    stsStrobe = 1'b1;
    busEn = be;
    push("R2");
    modelSts = v;
    @(negedge clk);
    stsStrobe = 1'b0;
    procData = ~v;
    busEn = 1'b1;
    push(be ? "R3" : "R11");
  endtask

  task automatic applyCombo(int c, logic [7:0] v);
    @(negedge clk);
    dbin = c[0];
    wrN = c[1];
    busEn = c[2];
    procData = v ^ 8'(c * 37);
    push(c == 7 ? "R3" : "");
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        logic [11:0] got;
        it = sbq.pop_front();
        got = {memRdN, memWrN, ioRdN, ioWrN, intAckN, dataOeToCpu,
               dataOeToSys, addrOe, diagWoN, diagStack, diagHltAck, diagM1};
        for (int i = 11; i >= 0; i--) begin
          checks++;
          if (got[i] !== it.e[i]) begin
            fails++;
            $display("FAIL %s: output bit %0d got %b expected %b (vector %b vs %b)",
                     reqOf(i, it.tag, it.be), i, got[i], it.e[i], got, it.e);
          end
        end
      end
    end
  end

  // driver
  initial begin
    // R1: reset with every input trying to provoke a strobe
    dbin = 1'b1; wrN = 1'b0; busEn = 1'b1; procData = 8'hFF; stsStrobe = 1'b1;
    repeat (2) begin
      @(negedge clk);
      push("R1");
    end
    @(negedge clk);
    rstN = 1'b1;
    stsStrobe = 1'b0;
    push("R1");
    for (int s = 0; s < 256; s++) begin
      loadSts(8'(s), ((s >> 3) & 1) == 0 ? 1'b1 : 1'b0);
      for (int c = 0; c < 8; c++) applyCombo(c, 8'(s));
      // leave lines active so the next load overlaps a live strobe
      @(negedge clk);
      dbin = 1'b1; wrN = 1'b0; busEn = 1'b1;
      push("");
    end
    wait (sbq.size() == 0);
    @(negedge clk);
    #2;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // watchdog
  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule